// File: doc/BRIEF.md
# Pseudo-Associative Cache Lookup Controller

This block sits in front of a direct-mapped line array and lets it behave like a two-way cache when a lookup misses. Each line location has a partner location in the other half of the array. The partner is found by inverting the most significant index bit. A read request first probes its home location. If that probe misses, a second probe reads the partner. A hit on the partner is a slow hit: it costs one cycle more than a normal hit but is much cheaper than a trip to memory. When both probes miss, the controller fetches the word from a memory port and installs it.

Each stored key holds the address tag together with the top index bit of the line's own address. A line therefore stays identifiable whether it sits at its home location or at the partner. After a slow hit the two lines swap places, so the line just used becomes a fast hit next time. After a refill the new line takes the home location, the line it pushes out moves to the partner, and whatever was at the partner is dropped.

The requester uses a ready/valid request handshake. It receives a one-cycle response pulse carrying the data and a status code, so it can tell a fast hit, a slow hit and a miss apart.

Top module: `pseudo_assoc_cache`

## Requirements
- R1: After reset, `cpu_req_ready` is 1 while `cpu_rsp_valid` and `mem_req_valid` are 0. Every location is empty, so the first request to any address completes as a miss.
- R2: If the home location (index = address bits [IDX_W-1:0]) holds the requested key, the response carries status 2'b01 (fast) and the stored data. `cpu_rsp_valid` rises one clock edge after the edge that accepted the request.
- R3: If the home location misses and the partner location (home index with its top bit inverted) holds the requested key, the response carries status 2'b10 (slow) and the stored data. `cpu_rsp_valid` rises two clock edges after the accepting edge.
- R4: After a slow hit, the two locations have exchanged contents. The next access to the same address is a fast hit, and the line that was at the home location is now found as a slow hit.
- R5: When both probes miss, exactly one `mem_req_valid` pulse is issued, carrying the request address. The response carries status 2'b11 (miss) and the word from `mem_rsp_data`, and it appears one edge after the edge that sampled `mem_rsp_valid`.
- R6: A refill writes the new line at the home location and moves the previous home line to the partner, discarding the partner's previous line. If the home location was empty, the partner location keeps its line.
- R7: From the accepting edge until its response, `cpu_req_ready` stays 0. Every accepted request gets exactly one response, and responses come back in request order.
- R8: `cpu_rsp_valid` is high for exactly one cycle per response, and its status is never 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Read request present |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_addr | input | ADDR_W | Word address of the request |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_kind | output | 2 | 01 fast hit, 10 slow hit, 11 miss |
| cpu_rsp_data | output | DATA_W | Returned word |
| mem_req_valid | output | 1 | One-cycle refill read request |
| mem_req_addr | output | ADDR_W | Address to fetch |
| mem_rsp_valid | input | 1 | Refill word present |
| mem_rsp_data | input | DATA_W | Refill word |

## Verification
Directed sequences place two addresses that share a home location, together with a third address whose home is their partner. These sequences separate a fast hit from a slow hit, show whether the swap happened, and show which line a refill evicts. A separate case probes an empty home location whose partner is occupied, which distinguishes a refill that keeps the partner line from one that wipes it. A long pseudo-random run over a small address pool mixes all three outcomes back to back. It checks data, status and latency against a reference model of the two-location placement rules, and it checks the address of each memory fetch.

// File: rtl/pac_pkg.sv
package pac_pkg;

  typedef enum logic [1:0] {
    RSP_NONE = 2'b00,
    RSP_FAST = 2'b01,
    RSP_SLOW = 2'b10,
    RSP_MISS = 2'b11
  } rsp_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRI,
    ST_ALT,
    ST_FILL,
    ST_FIX
  } ctl_state_e;

endpackage

// File: rtl/pac_line_store.sv
module pac_line_store #(
  parameter int IDX_W  = 3,
  parameter int KEY_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic              wr_en,
  input  logic              wr_valid,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [KEY_W-1:0]  rd_key,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = KEY_W + DATA_W;

  // key and data live in a plain array (no reset) so it maps to block RAM
  logic [ENT_W-1:0] ram [DEPTH];
  logic [ENT_W-1:0] q;
  // valid bits need a reset, so they are kept in flops
  logic [DEPTH-1:0] vbits;

  always_ff @(posedge clk) begin
    if (wr_en) ram[acc_idx] <= {wr_key, wr_data};
    q <= ram[acc_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vbits    <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) vbits[acc_idx] <= wr_valid;
      rd_valid <= vbits[acc_idx];
    end
  end

  assign rd_key  = q[ENT_W-1:DATA_W];
  assign rd_data = q[DATA_W-1:0];

endmodule

// File: rtl/pac_key_cmp.sv
module pac_key_cmp #(
  parameter int KEY_W = 10
) (
  input  logic             ent_valid,
  input  logic [KEY_W-1:0] ent_key,
  input  logic [KEY_W-1:0] want_key,
  output logic             hit
);
  assign hit = ent_valid && (ent_key == want_key);
endmodule

// File: rtl/pac_ctrl.sv
module pac_ctrl
  import pac_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cpu_req_valid,
  output logic                     cpu_req_ready,
  input  logic [ADDR_W-1:0]        cpu_req_addr,
  output logic                     cpu_rsp_valid,
  output logic [1:0]               cpu_rsp_kind,
  output logic [DATA_W-1:0]        cpu_rsp_data,
  output logic                     mem_req_valid,
  output logic [ADDR_W-1:0]        mem_req_addr,
  input  logic                     mem_rsp_valid,
  input  logic [DATA_W-1:0]        mem_rsp_data,
  input  logic                     probe_hit,
  input  logic                     rd_valid,
  input  logic [ADDR_W-IDX_W:0]    rd_key,
  input  logic [DATA_W-1:0]        rd_data,
  output logic [ADDR_W-IDX_W:0]    want_key,
  output logic [IDX_W-1:0]         st_idx,
  output logic                     st_we,
  output logic                     st_wvalid,
  output logic [ADDR_W-IDX_W:0]    st_wkey,
  output logic [DATA_W-1:0]        st_wdata
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int KEY_W = TAG_W + 1;
  localparam logic [IDX_W-1:0] MSB_MASK = IDX_W'(1) << (IDX_W - 1);

  ctl_state_e        state;
  logic [ADDR_W-1:0] req_addr;
  logic [IDX_W-1:0]  home_idx, alt_idx;
  logic              sv_valid;
  logic [KEY_W-1:0]  sv_key;
  logic [DATA_W-1:0] sv_data;
  logic              fix_we;
  rsp_kind_e         kind_q;

  assign home_idx      = req_addr[IDX_W-1:0];
  assign alt_idx       = home_idx ^ MSB_MASK;
  assign want_key      = req_addr[ADDR_W-1:IDX_W-1];
  assign cpu_req_ready = (state == ST_IDLE);
  assign cpu_rsp_kind  = kind_q;

  // array port: one access per cycle, read or write
  always_comb begin
    st_idx    = home_idx;
    st_we     = 1'b0;
    st_wvalid = 1'b0;
    st_wkey   = want_key;
    st_wdata  = sv_data;
    unique case (state)
      ST_IDLE: st_idx = cpu_req_addr[IDX_W-1:0];
      ST_PRI:  st_idx = alt_idx;
      ST_ALT: begin
        if (probe_hit) begin
          st_we     = 1'b1;
          st_wvalid = 1'b1;
          st_wdata  = rd_data;
        end
      end
      ST_FILL: begin
        if (mem_rsp_valid) begin
          st_we     = 1'b1;
          st_wvalid = 1'b1;
          st_wdata  = mem_rsp_data;
        end
      end
      ST_FIX: begin
        st_idx    = alt_idx;
        st_we     = fix_we;
        st_wvalid = sv_valid;
        st_wkey   = sv_key;
        st_wdata  = sv_data;
      end
      default: st_idx = home_idx;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      req_addr      <= '0;
      sv_valid      <= 1'b0;
      sv_key        <= '0;
      sv_data       <= '0;
      fix_we        <= 1'b0;
      cpu_rsp_valid <= 1'b0;
      kind_q        <= RSP_NONE;
      cpu_rsp_data  <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
    end else begin
      cpu_rsp_valid <= 1'b0;
      mem_req_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cpu_req_valid) begin
            req_addr <= cpu_req_addr;
            state    <= ST_PRI;
          end
        end
        ST_PRI: begin
          if (probe_hit) begin
            cpu_rsp_valid <= 1'b1;
            kind_q        <= RSP_FAST;
            cpu_rsp_data  <= rd_data;
            state         <= ST_IDLE;
          end else begin
            sv_valid <= rd_valid;
            sv_key   <= rd_key;
            sv_data  <= rd_data;
            state    <= ST_ALT;
          end
        end
        ST_ALT: begin
          if (probe_hit) begin
            cpu_rsp_valid <= 1'b1;
            kind_q        <= RSP_SLOW;
            cpu_rsp_data  <= rd_data;
            fix_we        <= 1'b1;
            state         <= ST_FIX;
          end else begin
            mem_req_valid <= 1'b1;
            mem_req_addr  <= req_addr;
            state         <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_rsp_valid) begin
            cpu_rsp_valid <= 1'b1;
            kind_q        <= RSP_MISS;
            cpu_rsp_data  <= mem_rsp_data;
            fix_we        <= sv_valid;
            state         <= ST_FIX;
          end
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pseudo_assoc_cache.sv
module pseudo_assoc_cache #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_rsp_valid,
  output logic [1:0]        cpu_rsp_kind,
  output logic [DATA_W-1:0] cpu_rsp_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int KEY_W = ADDR_W - IDX_W + 1;

  logic              rd_valid, probe_hit;
  logic [KEY_W-1:0]  rd_key, want_key, st_wkey;
  logic [DATA_W-1:0] rd_data, st_wdata;
  logic [IDX_W-1:0]  st_idx;
  logic              st_we, st_wvalid;

  pac_line_store #(.IDX_W(IDX_W), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .acc_idx(st_idx), .wr_en(st_we), .wr_valid(st_wvalid),
    .wr_key(st_wkey), .wr_data(st_wdata),
    .rd_valid(rd_valid), .rd_key(rd_key), .rd_data(rd_data)
  );

  pac_key_cmp #(.KEY_W(KEY_W)) u_cmp (
    .ent_valid(rd_valid), .ent_key(rd_key), .want_key(want_key), .hit(probe_hit)
  );

  pac_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_addr(cpu_req_addr),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_kind(cpu_rsp_kind), .cpu_rsp_data(cpu_rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .probe_hit(probe_hit), .rd_valid(rd_valid), .rd_key(rd_key), .rd_data(rd_data),
    .want_key(want_key), .st_idx(st_idx), .st_we(st_we), .st_wvalid(st_wvalid),
    .st_wkey(st_wkey), .st_wdata(st_wdata)
  );

endmodule

// File: rtl/pac_checker.sv
module pac_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic [ADDR_W-1:0] cpu_req_addr,
  input logic              cpu_rsp_valid,
  input logic [1:0]        cpu_rsp_kind,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid
);
  logic              pend;
  logic [ADDR_W-1:0] cap_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      cap_addr <= '0;
    end else if (cpu_req_valid && cpu_req_ready) begin
      pend     <= 1'b1;
      cap_addr <= cpu_req_addr;
    end else if (cpu_rsp_valid) begin
      pend <= 1'b0;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cpu_req_ready && !cpu_rsp_valid && !mem_req_valid)); // R1
  AST_FAST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (cpu_rsp_valid && cpu_rsp_kind == 2'b01) |-> $past(cpu_req_valid && cpu_req_ready, 2)); // R2
  AST_SLOW_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (cpu_rsp_valid && cpu_rsp_kind == 2'b10) |-> $past(cpu_req_valid && cpu_req_ready, 3)); // R3
  AST_MISS_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
    (cpu_rsp_valid && cpu_rsp_kind == 2'b11) |-> $past(mem_rsp_valid)); // R5
  AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (pend && mem_req_addr == cap_addr)); // R5
  AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid); // R5
  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (rst)
    (pend && !cpu_rsp_valid) |-> !cpu_req_ready); // R7
  AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    cpu_rsp_valid |-> pend); // R7
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_rsp_valid |=> !cpu_rsp_valid); // R8
  AST_KIND_CODED: assert property (@(posedge clk) disable iff (rst)
    cpu_rsp_valid |-> (cpu_rsp_kind != 2'b00)); // R8

endmodule

bind pseudo_assoc_cache pac_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_req_addr(cpu_req_addr), .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_kind(cpu_rsp_kind),
  .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/tb_pseudo_assoc_cache.sv
module tb_pseudo_assoc_cache;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 3;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int KEY_W  = ADDR_W - IDX_W + 1;
  localparam int MEM_LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req_valid = 1'b0;
  logic cpu_req_ready;
  logic [ADDR_W-1:0] cpu_req_addr = '0;
  logic cpu_rsp_valid;
  logic [1:0] cpu_rsp_kind;
  logic [DATA_W-1:0] cpu_rsp_data;
  logic mem_req_valid;
  logic [ADDR_W-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0] mem_rsp_data = '0;

  always #2 clk = ~clk;

  pseudo_assoc_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_addr(cpu_req_addr), .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_kind(cpu_rsp_kind),
    .cpu_rsp_data(cpu_rsp_data), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int n_fetch = 0;
  int n_exp_miss = 0;
  bit finished = 0;
  logic [ADDR_W-1:0] cur_addr = '0;

  always @(posedge clk) cyc <= cyc + 1;

  // reference placement model
  logic             m_v [DEPTH];
  logic [KEY_W-1:0] m_k [DEPTH];
  logic [DATA_W-1:0] m_d [DEPTH];

  // scoreboard queues
  logic [1:0]        q_kind [$];
  logic [DATA_W-1:0] q_data [$];
  string             q_req  [$];
  int                q_acc  [$];

  function automatic logic [DATA_W-1:0] memfn(input logic [ADDR_W-1:0] a);
    logic [31:0] t;
    t = {20'd0, a} * 32'd40503 ^ 32'h5A5A;
    return t[DATA_W-1:0];
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // driver: computes expected outcome from the model, then issues the request
  task automatic access(input logic [ADDR_W-1:0] a, input string rq);
    logic [IDX_W-1:0] h, p;
    logic [KEY_W-1:0] k;
    logic ov;
    logic [KEY_W-1:0] ok_;
    logic [DATA_W-1:0] od;
    h = a[IDX_W-1:0];
    p = h ^ (IDX_W'(1) << (IDX_W - 1));
    k = a[ADDR_W-1:IDX_W-1];
    if (m_v[h] && m_k[h] == k) begin
      q_kind.push_back(2'b01); q_data.push_back(m_d[h]);
    end else if (m_v[p] && m_k[p] == k) begin
      q_kind.push_back(2'b10); q_data.push_back(m_d[p]);
      ov = m_v[h]; ok_ = m_k[h]; od = m_d[h];
      m_v[h] = m_v[p]; m_k[h] = m_k[p]; m_d[h] = m_d[p];
      m_v[p] = ov; m_k[p] = ok_; m_d[p] = od;
    end else begin
      q_kind.push_back(2'b11); q_data.push_back(memfn(a));
      n_exp_miss++;
      if (m_v[h]) begin
        m_v[p] = 1'b1; m_k[p] = m_k[h]; m_d[p] = m_d[h];
      end
      m_v[h] = 1'b1; m_k[h] = k; m_d[h] = memfn(a);
    end
    q_req.push_back(rq);
    while (!cpu_req_ready) @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_addr  = a;
    cur_addr      = a;
    @(negedge clk);
    q_acc.push_back(cyc);
    cpu_req_valid = 1'b0;
  endtask

  // memory model
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid && !rst) begin
        n_fetch++;
        chk(mem_req_addr == cur_addr, "R5", "fetch address", 32'(mem_req_addr), 32'(cur_addr));
        repeat (MEM_LAT) @(negedge clk);
        mem_rsp_data  = memfn(mem_req_addr);
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // monitor
  initial begin
    bit prev_rsp = 0;
    bit stall_bad = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (prev_rsp)
          chk(!cpu_rsp_valid, "R8", "response pulse width", 32'(cpu_rsp_valid), 0);
        if (q_acc.size() > 0 && !cpu_rsp_valid && cpu_req_ready && !cpu_req_valid)
          stall_bad = 1;
        if (cpu_rsp_valid) begin
          if (q_acc.size() == 0) begin
            chk(0, "R7", "response without request", 1, 0);
          end else begin
            logic [1:0] ek;
            logic [DATA_W-1:0] ed;
            string rq;
            int lat;
            ek = q_kind.pop_front(); ed = q_data.pop_front();
            rq = q_req.pop_front(); lat = cyc - q_acc.pop_front();
            chk(cpu_rsp_kind == ek, rq, "status", 32'(cpu_rsp_kind), 32'(ek));
            chk(cpu_rsp_data == ed, rq, "data", 32'(cpu_rsp_data), 32'(ed));
            if (ek == 2'b01) chk(lat == 1, "R2", "fast latency", lat, 1);
            else if (ek == 2'b10) chk(lat == 2, "R3", "slow latency", lat, 2);
            else chk(lat == MEM_LAT + 3, "R5", "miss latency", lat, MEM_LAT + 3);
            chk(!stall_bad, "R7", "ready while busy", 32'(stall_bad), 0);
            stall_bad = 0;
          end
        end
        prev_rsp = cpu_rsp_valid;
      end
    end
  end

  task automatic finish_up;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_k[i] = '0; m_d[i] = '0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cpu_req_ready == 1'b1, "R1", "ready after reset", 32'(cpu_req_ready), 1);
    chk(cpu_rsp_valid == 1'b0, "R1", "rsp after reset", 32'(cpu_rsp_valid), 0);
    chk(mem_req_valid == 1'b0, "R1", "fetch after reset", 32'(mem_req_valid), 0);
    access(12'h013, "R1");   // cold miss, home 3
    access(12'h013, "R2");   // fast hit
    access(12'h023, "R6");   // same home: old line moves to 7
    access(12'h013, "R3");   // slow hit at partner, swap
    access(12'h013, "R4");   // now fast
    access(12'h023, "R4");   // displaced line found at partner
    access(12'h017, "R6");   // home 7: both miss, line at 3 dropped
    access(12'h013, "R6");   // moved line now at its home
    access(12'h023, "R6");   // dropped line misses
    access(12'h045, "R6");   // home 5 fill
    access(12'h041, "R6");   // home 1 empty: partner 5 must survive
    access(12'h045, "R6");   // still fast
    r = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      r = r * 32'd1103515245 + 32'd12345;
      access({6'd0, r[21:16]}, "R7");
    end
    while (q_acc.size() > 0 || q_kind.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(n_fetch == n_exp_miss, "R5", "fetch count", 32'(n_fetch), 32'(n_exp_miss));
    finish_up();
  end

endmodule